// File: doc/BRIEF.md
# Bit-addressed operand pointer resolver

This block takes one operand of an instruction together with its addressing mode. It turns the operand into a bit address inside a 64K-bit memory and then carries out the reads or writes that the mode needs. When an operand is used as a pointer it can be 2, 4 or 16 bits wide.

A 16-bit pointer names any bit of memory directly. A 2-bit or 4-bit pointer is an index into a fixed table of locations. The lowest locations in that table hold pointers of their own, and the width of each stored pointer depends on where it lives, not on the instruction that uses it.

Read requests return a value on the result port. Write requests store the supplied data. One output mode stores through a pointer held in memory and then advances that pointer. Modes outside the fixed set finish at once with a flag raised and touch no memory.

The memory port is bit-addressed and moves 16 bits per access. It has a per-bit write mask, and read data returns one cycle after the read is issued.

Top module: `rp_operand_resolver`

## Requirements
- R1: After reset `done`, `unsupported` and `mem_en` are low and `req_ready` is high. `mem_en` is never high while `req_ready` is high. `done` is a one-cycle pulse for each accepted request.
- R2: With `req_opw`=01 only `req_operand[3:0]` is used as a pointer index. Index 0 gives bit 0, the program-counter word. Indices 1..4 give bits 16..19. Indices 5..7 give bits 20, 24 and 28. Indices 8..15 give bits 32, 48, …, 144 in steps of 16.
- R3: With `req_opw`=00 only `req_operand[1:0]` is used. Values 0, 1, 2 and 3 give bits 0, 16, 20 and 32.
- R4: With `req_opw`=10 or 11 the whole 16-bit operand is the bit address.
- R5: A read with mode 00 (immediate) returns the operand ANDed with the data-width mask and makes no memory access. The data-width field `req_dw` selects the mask: 00 keeps 1 bit, 01 keeps 4 bits, 10 and 11 keep 16 bits. `done` rises one cycle after the accepting edge.
- R6: A read with mode 01 (memory) returns the 16 bits starting at the resolved address, masked by `req_dw`. It makes exactly one access and `done` rises three cycles after acceptance.
- R7: A read with mode 10 (indirect) first reads the pointer stored at the resolved address A. The width of that stored pointer is set by A: 1 bit at A=16..19, 4 bits at A=20, 24 and 28, and 16 bits everywhere else (including bit 0 and every address from 32 up). The block then reads the value through that pointer. It makes two accesses and `done` rises four cycles after acceptance.
- R8: A stored pointer 1 or 4 bits wide is not zero-extended. Its value is passed through the same index table as R2 before it is used as an address.
- R9: A write with mode 01 (memory) stores `req_data` at the resolved address. Only the low 1, 4 or 16 bits selected by `req_dw` change. It makes one access and `done` rises two cycles after acceptance.
- R10: A write with mode 10 (indirect) stores `req_data` through the stored pointer found at the resolved address. The pointer is read and expanded as in R7 and R8. It makes two accesses and `done` rises three cycles after acceptance.
- R11: A write with mode 00 (indirect post-increment) stores through the stored pointer as in R10. It then writes back that pointer plus one, wrapping modulo its own width, and only the pointer's bits change. It makes three accesses and `done` rises four cycles after acceptance.
- R12: Mode 11 on either a read or a write is custom. It raises `unsupported` together with `done` one cycle after acceptance and makes no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; a request is taken on this cycle's edge |
| req_write | input | 1 | 0 = fetch input operand, 1 = store result |
| req_mode | input | 2 | Addressing mode (see R5..R12) |
| req_opw | input | 2 | Pointer width of the operand: 00 two-bit, 01 four-bit, 1x sixteen-bit |
| req_dw | input | 2 | Data width: 00 one bit, 01 four bits, 1x sixteen bits |
| req_operand | input | 16 | Operand value |
| req_data | input | 16 | Result data to store |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write select |
| mem_addr | output | 16 | Bit address of the first bit accessed |
| mem_wdata | output | 16 | Write data, bit i goes to address+i |
| mem_wmask | output | 16 | Per-bit write enable |
| mem_rdata | input | 16 | Read data, one cycle after the read |
| done | output | 1 | Request finished (one-cycle pulse) |
| unsupported | output | 1 | Custom mode seen, valid with done |
| result | output | 16 | Fetched operand value, valid from done onward |

## Verification
The bench builds the block with its default 16-bit address and word widths. The bench memory folds addresses modulo 4096, which keeps every aliased access consistent. Under these defaults every short index can be swept: all 16 four-bit values and all 4 two-bit values, through every mode and every data width. That covers every class of stored pointer, including pointers that overlap their own location. Seeded memory images supply arbitrary stored pointers. After each write the whole memory image is compared against a model, so a stray bit is caught. Wrap-around of 1-, 4- and 16-bit stored pointers is forced by preloading them at their maximum value.

// File: rtl/rp_pkg.sv
package rp_pkg;

    // Address space and access word of the memory port
    localparam int unsigned RP_AW  = 16;
    localparam int unsigned RP_WW  = 16;
    // Short pointer index width (the largest short form)
    localparam int unsigned RP_SIW = 4;

    // Location table: single-bit slots, nibble slots, wide slots
    localparam int unsigned RP_ONE_BASE  = 16;
    localparam int unsigned RP_ONE_CNT   = 4;
    localparam int unsigned RP_NIB_BASE  = 20;
    localparam int unsigned RP_NIB_STEP  = 4;
    localparam int unsigned RP_NIB_CNT   = 3;
    localparam int unsigned RP_WIDE_BASE = 32;
    localparam int unsigned RP_WIDE_STEP = 16;

    // Table indices reached by the four 2-bit pointer values
    localparam int unsigned RP_IDX_ONE  = 1;
    localparam int unsigned RP_IDX_NIB  = 1 + RP_ONE_CNT;
    localparam int unsigned RP_IDX_WIDE = 1 + RP_ONE_CNT + RP_NIB_CNT;

    localparam logic [1:0] MD_IMM  = 2'd0;  // read side
    localparam logic [1:0] MD_INC  = 2'd0;  // write side
    localparam logic [1:0] MD_MEM  = 2'd1;
    localparam logic [1:0] MD_IND  = 2'd2;
    localparam logic [1:0] MD_CUST = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_USE,
        ST_RD,
        ST_TAKE,
        ST_WR,
        ST_BUMP
    } rp_state_e;

    typedef enum logic [1:0] {
        PW_ONE,
        PW_NIB,
        PW_FULL
    } rp_pw_e;

endpackage

// File: rtl/rp_short_map.sv
module rp_short_map
    import rp_pkg::*;
#(
    parameter int unsigned AW  = RP_AW,
    parameter int unsigned IW  = RP_SIW
) (
    input  logic [IW-1:0] idx,
    output logic [AW-1:0] loc
);

    localparam int unsigned NIB_FIRST  = 1 + RP_ONE_CNT;
    localparam int unsigned WIDE_FIRST = NIB_FIRST + RP_NIB_CNT;

    int unsigned iv;

    always_comb begin
        iv = 32'(idx);
        if (iv == 0) begin
            loc = '0;
        end else if (iv < NIB_FIRST) begin
            loc = AW'(RP_ONE_BASE + iv - 1);
        end else if (iv < WIDE_FIRST) begin
            loc = AW'(RP_NIB_BASE + (iv - NIB_FIRST) * RP_NIB_STEP);
        end else begin
            loc = AW'(RP_WIDE_BASE + (iv - WIDE_FIRST) * RP_WIDE_STEP);
        end
    end

endmodule

// File: rtl/rp_loc_class.sv
module rp_loc_class
    import rp_pkg::*;
#(
    parameter int unsigned AW = RP_AW
) (
    input  logic [AW-1:0] loc,
    output rp_pw_e        cls
);

    localparam int unsigned NIB_END = RP_NIB_BASE + RP_NIB_CNT * RP_NIB_STEP;

    int unsigned a;

    always_comb begin
        a = 32'(loc);
        if (a >= RP_ONE_BASE && a < RP_ONE_BASE + RP_ONE_CNT) begin
            cls = PW_ONE;
        end else if (a >= RP_NIB_BASE && a < NIB_END && ((a - RP_NIB_BASE) % RP_NIB_STEP) == 0) begin
            cls = PW_NIB;
        end else begin
            cls = PW_FULL;
        end
    end

endmodule

// File: rtl/rp_operand_resolver.sv
module rp_operand_resolver
    import rp_pkg::*;
#(
    parameter int unsigned AW  = RP_AW,
    parameter int unsigned WW  = RP_WW,
    parameter int unsigned SIW = RP_SIW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [1:0]    req_mode,
    input  logic [1:0]    req_opw,
    input  logic [1:0]    req_dw,
    input  logic [AW-1:0] req_operand,
    input  logic [WW-1:0] req_data,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [WW-1:0] mem_wdata,
    output logic [WW-1:0] mem_wmask,
    input  logic [WW-1:0] mem_rdata,
    output logic          done,
    output logic          unsupported,
    output logic [WW-1:0] result
);

    typedef struct packed {
        rp_state_e     state;
        logic          wr;
        logic [1:0]    mode;
        logic [1:0]    dw;
        logic [WW-1:0] data;
        logic [AW-1:0] addr;
        logic [WW-1:0] ptr_next;
        logic [WW-1:0] result;
        logic          done;
        logic          unsup;
    } regs_t;

    function automatic logic [WW-1:0] dw_mask(input logic [1:0] dw);
        case (dw)
            2'd0:    return WW'(1);
            2'd1:    return WW'(4'hF);
            default: return '1;
        endcase
    endfunction

    function automatic logic [WW-1:0] pw_mask(input rp_pw_e pw);
        case (pw)
            PW_ONE:  return WW'(1);
            PW_NIB:  return WW'(4'hF);
            default: return '1;
        endcase
    endfunction

    regs_t q, d;

    // Operand as pointer: 2-bit values pick a subset of table indices
    logic [SIW-1:0] op_idx;
    logic [AW-1:0]  op_loc;
    logic [AW-1:0]  op_addr;

    always_comb begin
        case (req_operand[1:0])
            2'd0:    op_idx = '0;
            2'd1:    op_idx = SIW'(RP_IDX_ONE);
            2'd2:    op_idx = SIW'(RP_IDX_NIB);
            default: op_idx = SIW'(RP_IDX_WIDE);
        endcase
        if (req_opw[0]) op_idx = req_operand[SIW-1:0];
    end

    rp_short_map #(.AW(AW), .IW(SIW)) u_op_map (
        .idx (op_idx),
        .loc (op_loc)
    );

    assign op_addr = req_opw[1] ? req_operand : op_loc;

    // Stored pointer: width from its own location, short forms re-expanded
    rp_pw_e         st_cls;
    logic [SIW-1:0] st_idx;
    logic [AW-1:0]  st_loc;
    logic [AW-1:0]  st_addr;
    logic [WW-1:0]  st_inc;

    rp_loc_class #(.AW(AW)) u_loc_class (
        .loc (q.addr),
        .cls (st_cls)
    );

    assign st_idx = (st_cls == PW_ONE) ? {{(SIW-1){1'b0}}, mem_rdata[0]} : mem_rdata[SIW-1:0];

    rp_short_map #(.AW(AW), .IW(SIW)) u_st_map (
        .idx (st_idx),
        .loc (st_loc)
    );

    assign st_addr = (st_cls == PW_FULL) ? mem_rdata[AW-1:0] : st_loc;
    assign st_inc  = (mem_rdata + WW'(1)) & pw_mask(st_cls);

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        d.unsup   = 1'b0;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = q.addr;
        mem_wdata = q.data;
        mem_wmask = dw_mask(q.dw);
        case (q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    d.wr   = req_write;
                    d.mode = req_mode;
                    d.dw   = req_dw;
                    d.data = req_data;
                    d.addr = op_addr;
                    if (req_mode == MD_CUST) begin
                        d.done  = 1'b1;
                        d.unsup = 1'b1;
                    end else if (!req_write) begin
                        if (req_mode == MD_IMM) begin
                            d.result = WW'(req_operand) & dw_mask(req_dw);
                            d.done   = 1'b1;
                        end else if (req_mode == MD_MEM) begin
                            d.state = ST_RD;
                        end else begin
                            d.state = ST_FETCH;
                        end
                    end else begin
                        d.state = (req_mode == MD_MEM) ? ST_WR : ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                mem_en  = 1'b1;
                d.state = ST_USE;
            end
            ST_USE: begin
                mem_en     = 1'b1;
                mem_addr   = st_addr;
                d.ptr_next = st_inc;
                if (!q.wr) begin
                    d.state = ST_TAKE;
                end else begin
                    mem_we = 1'b1;
                    if (q.mode == MD_INC) begin
                        d.state = ST_BUMP;
                    end else begin
                        d.state = ST_IDLE;
                        d.done  = 1'b1;
                    end
                end
            end
            ST_RD: begin
                mem_en  = 1'b1;
                d.state = ST_TAKE;
            end
            ST_TAKE: begin
                d.result = mem_rdata & dw_mask(q.dw);
                d.done   = 1'b1;
                d.state  = ST_IDLE;
            end
            ST_WR: begin
                mem_en  = 1'b1;
                mem_we  = 1'b1;
                d.done  = 1'b1;
                d.state = ST_IDLE;
            end
            ST_BUMP: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = q.ptr_next;
                mem_wmask = pw_mask(st_cls);
                d.done    = 1'b1;
                d.state   = ST_IDLE;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign req_ready   = (q.state == ST_IDLE);
    assign done        = q.done;
    assign unsupported = q.unsup;
    assign result      = q.result;

    // R1: the memory port stays quiet whenever a new request can be taken
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_en);

    // R1: done lasts one cycle unless a fresh request was taken meanwhile
    p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done || $past(req_valid && req_ready)));

    // R5: immediate fetch completes on the next cycle with the masked operand
    p_imm_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write && req_mode == MD_IMM)
        |=> (done && !unsupported &&
             result == ($past(WW'(req_operand)) & $past(dw_mask(req_dw)))));

    // R9: every write mask covers exactly 1, 4 or 16 low bits
    p_wmask_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |->
        (mem_wmask == WW'(1) || mem_wmask == WW'(4'hF) || mem_wmask == '1));

    // R11: the pointer write-back directly follows the data write
    p_bump_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we && q.state == ST_BUMP) |-> $past(mem_en && mem_we));

    // R12: custom mode ends at once with the flag raised
    p_custom_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_mode == MD_CUST) |=> (done && unsupported));

endmodule

// File: tb/rp_operand_resolver_test.sv
module rp_operand_resolver_test;

    localparam int MEMB = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_mode = '0;
    logic [1:0]  req_opw = '0;
    logic [1:0]  req_dw = '0;
    logic [15:0] req_operand = '0;
    logic [15:0] req_data = '0;
    logic        mem_en, mem_we;
    logic [15:0] mem_addr, mem_wdata, mem_wmask;
    logic [15:0] mem_rdata = '0;
    logic        done, unsupported;
    logic [15:0] result;

    logic [MEMB-1:0] bmem = '0;
    logic [MEMB-1:0] preload = '0;
    logic            do_load = 1'b0;
    int              acc = 0;
    int              vectors = 0;
    int              fails = 0;
    bit              finished = 0;

    always #10 clk = ~clk;

    rp_operand_resolver uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_mode(req_mode), .req_opw(req_opw), .req_dw(req_dw),
        .req_operand(req_operand), .req_data(req_data),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_wmask(mem_wmask), .mem_rdata(mem_rdata),
        .done(done), .unsupported(unsupported), .result(result)
    );

    // Bench memory: addresses fold modulo MEMB, one-cycle read latency
    always @(posedge clk) begin
        if (do_load) begin
            bmem <= preload;
        end else begin
            if (mem_en) acc <= acc + 1;
            if (mem_en && !mem_we) mem_rdata <= rd16(bmem, int'(mem_addr));
            if (mem_en && mem_we)
                for (int i = 0; i < 16; i++)
                    if (mem_wmask[i]) bmem[(int'(mem_addr) + i) % MEMB] <= mem_wdata[i];
        end
    end

    function automatic int t4(input int v);
        if (v == 0) return 0;
        if (v <= 4) return 15 + v;
        if (v <= 7) return 20 + 4 * (v - 5);
        return 32 + 16 * (v - 8);
    endfunction

    function automatic int t2(input int v);
        case (v)
            0: return 0;
            1: return 16;
            2: return 20;
            default: return 32;
        endcase
    endfunction

    function automatic int resolve(input int opw, input int op);
        if (opw >= 2) return op;
        if (opw == 1) return t4(op % 16);
        return t2(op % 4);
    endfunction

    function automatic int locw(input int a);
        if (a >= 16 && a <= 19) return 1;
        if (a == 20 || a == 24 || a == 28) return 4;
        return 16;
    endfunction

    function automatic int wmsk(input int w);
        return (w == 1) ? 1 : (w == 4) ? 15 : 16'hFFFF;
    endfunction

    function automatic int dmsk(input int dw);
        return (dw == 0) ? 1 : (dw == 1) ? 15 : 16'hFFFF;
    endfunction

    function automatic logic [15:0] rd16(input logic [MEMB-1:0] m, input int a);
        logic [15:0] r;
        for (int i = 0; i < 16; i++) r[i] = m[(a + i) % MEMB];
        return r;
    endfunction

    function automatic logic [MEMB-1:0] wr16(input logic [MEMB-1:0] m, input int a,
                                             input int data, input int mask);
        logic [MEMB-1:0] r;
        r = m;
        for (int i = 0; i < 16; i++)
            if (mask[i]) r[(a + i) % MEMB] = data[i];
        return r;
    endfunction

    function automatic int expand(input int raw, input int w);
        if (w == 16) return raw;
        if (w == 1) return t4(raw & 1);
        return t4(raw & 15);
    endfunction

    function automatic logic pbit(input int i, input int seed);
        logic [31:0] h;
        h = 32'(i) * 32'h9E3779B1 ^ 32'(seed) * 32'h85EBCA6B;
        h = h ^ (h >> 15);
        return h[0] ^ h[7];
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_mem(input string req, input logic [MEMB-1:0] exp);
        int k;
        vectors++;
        if (bmem !== exp) begin
            k = 0;
            while (k < MEMB - 1 && bmem[k] === exp[k]) k++;
            fails++;
            $display("FAIL %s memory bit %0d act=%0h exp=%0h", req, k, bmem[k], exp[k]);
        end
    endtask

    task automatic load_img(input logic [MEMB-1:0] img);
        @(negedge clk);
        preload = img;
        do_load = 1'b1;
        @(negedge clk);
        do_load = 1'b0;
    endtask

    task automatic load_seed(input int seed);
        logic [MEMB-1:0] img;
        for (int i = 0; i < MEMB; i++) img[i] = pbit(i, seed);
        load_img(img);
    endtask

    task automatic do_req(input bit wr, input int mode, input int opw, input int dw,
                          input int op, input int data,
                          output logic [15:0] res, output int lat, output int accs,
                          output logic uns);
        int a0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_write   = wr;
        req_mode    = 2'(mode);
        req_opw     = 2'(opw);
        req_dw      = 2'(dw);
        req_operand = 16'(op);
        req_data    = 16'(data);
        req_valid   = 1'b1;
        a0 = acc;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!done && lat < 12) begin
            @(negedge clk);
            lat++;
        end
        res  = result;
        uns  = unsupported;
        accs = acc - a0;
    endtask

    task automatic run_read(input string req, input int mode, input int opw, input int dw,
                            input int op, input int exp, input int elat, input int eacc);
        logic [15:0] res;
        int lat, accs;
        logic uns;
        do_req(1'b0, mode, opw, dw, op, 0, res, lat, accs, uns);
        check(res == 16'(exp), req, "result", res, exp);
        check(lat == elat, req, "latency", lat, elat);
        check(accs == eacc, req, "accesses", accs, eacc);
        check(uns == 1'b0, req, "unsupported", uns, 0);
    endtask

    task automatic run_write(input string req, input int mode, input int opw, input int dw,
                             input int op, input int data, input logic [MEMB-1:0] exp,
                             input int elat, input int eacc);
        logic [15:0] res;
        int lat, accs;
        logic uns;
        do_req(1'b1, mode, opw, dw, op, data, res, lat, accs, uns);
        chk_mem(req, exp);
        check(lat == elat, req, "latency", lat, elat);
        check(accs == eacc, req, "accesses", accs, eacc);
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [MEMB-1:0] e;
        logic [15:0] res;
        int lat, accs, a, w, raw, p, op, data;
        logic uns;

        repeat (3) @(negedge clk);
        // R1: reset state
        check(done == 1'b0, "R1", "done in reset", done, 0);
        check(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
        check(mem_en == 1'b0, "R1", "mem_en in reset", mem_en, 0);
        check(unsupported == 1'b0, "R1", "unsupported in reset", unsupported, 0);
        rst_n = 1'b1;

        load_seed(1);

        // R5: immediate values under each data width
        for (int dw = 0; dw < 3; dw++)
            for (int v = 0; v < 16; v++) begin
                op = (v * 4097) ^ 16'h5A3C;
                run_read("R5", 0, v % 4, dw, op, op & dmsk(dw), 1, 0);
            end

        // R1: done drops after its pulse
        @(negedge clk);
        check(done == 1'b0, "R1", "done after pulse", done, 0);

        // R2: every 4-bit index, upper operand bits set to junk
        for (int v = 0; v < 16; v++)
            for (int dw = 0; dw < 3; dw++) begin
                op = 16'hABC0 | v;
                run_read("R2", 1, 1, dw, op, rd16(bmem, t4(v)) & dmsk(dw), 3, 1);
            end

        // R3: every 2-bit value, bits above [1:0] set
        for (int v = 0; v < 4; v++) begin
            op = 16'hBEEC | v;
            run_read("R3", 1, 0, 2, op, rd16(bmem, t2(v)), 3, 1);
        end

        // R4: direct 16-bit addresses, both encodings of the wide form
        for (int k = 0; k < 32; k++) begin
            op = (k * 2053 + 7) & 16'hFFFF;
            run_read("R4", 1, 2 + (k % 2), 2, op, rd16(bmem, op), 3, 1);
        end
        run_read("R4", 1, 2, 2, 16'hFFFA, rd16(bmem, 16'hFFFA), 3, 1);

        // R6: memory mode with a second image
        load_seed(7);
        for (int v = 0; v < 16; v++)
            run_read("R6", 1, 1, v % 3, v, rd16(bmem, t4(v)) & dmsk(v % 3), 3, 1);

        // R7, R8: indirect reads through stored pointers of every class
        for (int seed = 2; seed < 5; seed++) begin
            load_seed(seed);
            for (int v = 0; v < 16; v++) begin
                a = t4(v);
                w = locw(a);
                raw = int'(rd16(bmem, a)) & wmsk(w);
                p = expand(raw, w);
                run_read((w == 16) ? "R7" : "R8", 2, 1, 2, v, rd16(bmem, p), 4, 2);
            end
            for (int v = 0; v < 4; v++) begin
                a = t2(v);
                w = locw(a);
                raw = int'(rd16(bmem, a)) & wmsk(w);
                p = expand(raw, w);
                run_read("R7", 2, 0, 1, v, rd16(bmem, p) & 15, 4, 2);
            end
        end

        // R9: memory writes, only masked bits change
        load_seed(11);
        for (int v = 0; v < 16; v++)
            for (int dw = 0; dw < 3; dw++) begin
                data = 16'hC35A ^ (v * 16'h1111) ^ dw;
                e = wr16(bmem, t4(v), data, dmsk(dw));
                run_write("R9", 1, 1, dw, v, data, e, 2, 1);
            end

        // R10: indirect writes
        load_seed(12);
        for (int v = 0; v < 16; v++) begin
            a = t4(v);
            w = locw(a);
            raw = int'(rd16(bmem, a)) & wmsk(w);
            p = expand(raw, w);
            data = 16'h9E71 ^ (v * 16'h0F0F);
            e = wr16(bmem, p, data, dmsk(v % 3));
            run_write("R10", 2, 1, v % 3, v, data, e, 3, 2);
        end

        // R11: indirect post-increment
        load_seed(13);
        for (int v = 0; v < 16; v++) begin
            a = t4(v);
            w = locw(a);
            raw = int'(rd16(bmem, a)) & wmsk(w);
            p = expand(raw, w);
            data = 16'h3D29 + v * 77;
            e = wr16(bmem, p, data, dmsk(2));
            e = wr16(e, a, (raw + 1) & wmsk(w), wmsk(w));
            run_write("R11", 0, 1, 2, v, data, e, 4, 3);
        end

        // R11: wrap of 1-, 4- and 16-bit stored pointers held at their maximum
        e = bmem;
        e = wr16(e, 16, 1, 1);
        e = wr16(e, 20, 15, 15);
        e = wr16(e, 32, 16'hFFFF, 16'hFFFF);
        load_img(e);
        for (int k = 0; k < 3; k++) begin
            op = (k == 0) ? 1 : (k == 1) ? 5 : 8;
            a = t4(op);
            w = locw(a);
            raw = int'(rd16(bmem, a)) & wmsk(w);
            check(raw == wmsk(w), "R11", "preloaded max pointer", raw, wmsk(w));
            p = expand(raw, w);
            e = wr16(bmem, p, 16'hA5A5, 1);
            e = wr16(e, a, 0, wmsk(w));
            run_write("R11", 0, 1, 0, op, 16'hA5A5, e, 4, 3);
            check((int'(rd16(bmem, a)) & wmsk(w)) == 0, "R11", "wrapped pointer",
                  int'(rd16(bmem, a)) & wmsk(w), 0);
        end

        // R12: custom mode on both sides
        for (int k = 0; k < 4; k++) begin
            e = bmem;
            do_req(k[0], 3, k % 3, 2, 16'h0123 * k, 16'hFFFF, res, lat, accs, uns);
            check(uns == 1'b1, "R12", "unsupported", uns, 1);
            check(lat == 1, "R12", "latency", lat, 1);
            check(accs == 0, "R12", "accesses", accs, 0);
            chk_mem("R12", e);
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule